// File: doc/BRIEF.md
# Carry-Chain Integer Adder with Status Flags

This unit adds two integers at a selectable width of 8, 16, 32 or 64 bits and produces the six arithmetic status flags that follow from the sum. It has three variants. The first is a plain add. The second also adds the incoming carry flag. The third is a carry-only chain step that adds the incoming carry but updates nothing except the carry flag. The chain step lets a long multi-word addition run without disturbing the other condition bits.

The second addend is either a full-width source value or an immediate. An immediate is 8 or 32 bits wide and is sign-extended to the operand width before the add. The caller supplies the current flag bits. The unit returns the sum, masked to the operand width. It also returns the merged flag word and a write-enable per flag. A flag whose enable is low is passed through unchanged from the value supplied.

There is one register stage. An operation presented with `inValid` in one cycle appears on the outputs, qualified by `outValid`, after the next rising clock edge.

Top module: `carry_chain_adder`

## Requirements
- R1: With `opSel`=0 (plain add) the result is `dstVal` plus the second addend, truncated to the operand width; the incoming carry flag has no effect.
- R2: With `opSel`=1 (add with carry) the incoming carry flag (`flagsIn` bit 0) is added as a third term.
- R3: The carry flag (flag bit 0) is the unsigned carry out of the top bit of the selected width; `widthSel` 0,1,2,3 selects 8,16,32,64 bits.
- R4: The overflow flag (bit 5) is set when both addends have equal sign bits and the result's sign bit differs, with the carry-in counted in the sum.
- R5: The sign flag (bit 4) equals the top bit of the result at the operand width, and the zero flag (bit 3) is set when the width-masked result is all zero.
- R6: The auxiliary flag (bit 2) is the carry out of bit 3 of the sum, carry-in included. The parity flag (bit 1) is 1 when the low 8 result bits hold an even number of ones.
- R7: With `opSel`=2 (carry-only chain add, 32 or 64 bits) the sum includes the incoming carry, only `flagWe` bit 0 is high, and flag bits 5..1 on `flagsOut` equal those on `flagsIn`.
- R8: `opSel`=3, or `opSel`=2 with an 8- or 16-bit width, is rejected: `flagWe` is all zero, `resultOut` is zero and `flagsOut` equals `flagsIn`.
- R9: With `immSel`=1 and `immWide`=0, `immVal[7:0]` is sign-extended to the operand width and used as the second addend.
- R10: With `immSel`=1 and `immWide`=1, `immVal[31:0]` is sign-extended and used as the second addend, so a negative 32-bit immediate subtracts from a 64-bit destination.
- R11: Result bits above the selected operand width are zero, whatever the upper input bits hold.
- R12: Outputs follow `inValid` by exactly one clock. When `outValid` is low, `flagWe` is all zero. After reset, `outValid`, `flagWe` and `resultOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| opSel | input | 2 | 0 plain add, 1 add with carry, 2 carry-only chain add, 3 reserved |
| widthSel | input | 2 | Operand width: 0=8, 1=16, 2=32, 3=64 bits |
| dstVal | input | 64 | Destination (first) addend |
| srcVal | input | 64 | Register source addend, used when immSel is 0 |
| immSel | input | 1 | Take the second addend from immVal |
| immWide | input | 1 | 0: 8-bit immediate, 1: 32-bit immediate |
| immVal | input | 32 | Immediate bits |
| flagsIn | input | 6 | Current flags: 0 carry, 1 parity, 2 aux, 3 zero, 4 sign, 5 overflow |
| outValid | output | 1 | Result and flags are valid |
| resultOut | output | 64 | Sum masked to the operand width |
| flagsOut | output | 6 | Merged flag word, same bit order as flagsIn |
| flagWe | output | 6 | Per-flag write enable |

## Verification
The hard cases are those where the carry-out and the signed overflow both fire in the same cycle, and where the zero flag and the carry-out fire together. Adding 0x80 and 0x80 at 8 bits raises carry, overflow and zero at once. All-ones plus zero with a carry-in of one, at 32 and 64 bits, drives a carry produced only by the carry-in term through every bit of the chain. Each case goes through a scoreboard whose expectations come from a separate model of the flag rules. Many random operands are run as well, and the bench judges the full result, the merged flags and the write-enables of each one.

// File: rtl/cca_pkg.sv
package cca_pkg;

  localparam int DATA_W     = 64;
  localparam int IMM_W      = 32;
  localparam int NUM_FLAGS  = 6;
  localparam int NUM_WIDTHS = 4;

  // flag bit positions in flagsIn / flagsOut / flagWe
  localparam int FL_CARRY = 0;
  localparam int FL_PAR   = 1;
  localparam int FL_AUX   = 2;
  localparam int FL_ZERO  = 3;
  localparam int FL_SIGN  = 4;
  localparam int FL_OVF   = 5;

  typedef enum logic [1:0] {
    OP_ADD       = 2'd0,
    OP_ADDC      = 2'd1,
    OP_CHAIN     = 2'd2,
    OP_RESERVED  = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_64 = 2'd3
  } widthKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       accept;       // legal operation
    logic       addCarryIn;   // include incoming carry in the sum
    logic       writeCarry;   // carry flag is written
    logic       writeOthers;  // the other five flags are written
    logic [1:0] widthIdx;     // lane selector
  } ctrlStrobe_t;

endpackage

// File: rtl/cca_ctrl.sv
module cca_ctrl
  import cca_pkg::*;
(
  input  logic [1:0]  opSel,
  input  logic [1:0]  widthSel,
  output ctrlStrobe_t strobe
);

  logic isReserved;
  logic isChain;
  logic isNarrow;
  logic legal;

  always_comb begin
    isReserved = (opSel == OP_RESERVED);
    isChain    = (opSel == OP_CHAIN);
    isNarrow   = (widthSel == WID_8) || (widthSel == WID_16);
    // the chain step exists only at 32 and 64 bits
    legal      = !isReserved && !(isChain && isNarrow);

    strobe.accept      = legal;
    strobe.addCarryIn  = legal && (opSel != OP_ADD);
    strobe.writeCarry  = legal;
    strobe.writeOthers = legal && !isChain;
    strobe.widthIdx    = widthSel;
  end

endmodule

// File: rtl/cca_datapath.sv
module cca_datapath
  import cca_pkg::*;
#(
  parameter int DATA_W     = cca_pkg::DATA_W,
  parameter int IMM_W      = cca_pkg::IMM_W,
  parameter int NUM_FLAGS  = cca_pkg::NUM_FLAGS,
  parameter int NUM_WIDTHS = cca_pkg::NUM_WIDTHS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  ctrlStrobe_t          strobe,
  input  logic [DATA_W-1:0]    dstVal,
  input  logic [DATA_W-1:0]    srcVal,
  input  logic                 immSel,
  input  logic                 immWide,
  input  logic [IMM_W-1:0]     immVal,
  input  logic [NUM_FLAGS-1:0] flagsIn,
  output logic                 outValid,
  output logic [DATA_W-1:0]    resultOut,
  output logic [NUM_FLAGS-1:0] flagsOut,
  output logic [NUM_FLAGS-1:0] flagWe
);

  localparam int SUM_W   = DATA_W + 1;
  localparam int SHORT_W = 8;

  // per-lane masks and top-bit taps
  logic [DATA_W-1:0]     laneMask [NUM_WIDTHS];
  logic [NUM_WIDTHS-1:0] carryAt;
  logic [NUM_WIDTHS-1:0] signA;
  logic [NUM_WIDTHS-1:0] signB;
  logic [NUM_WIDTHS-1:0] signR;

  logic [DATA_W-1:0] immShort;
  logic [DATA_W-1:0] immLong;
  logic [DATA_W-1:0] addendB;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] activeMask;
  logic              carryIn;
  logic [SUM_W-1:0]  sumFull;
  logic [DATA_W-1:0] sumMasked;

  logic [NUM_FLAGS-1:0] freshFlags;
  logic [NUM_FLAGS-1:0] writeMask;
  logic [NUM_FLAGS-1:0] mergedFlags;

  // immediate widening
  assign immShort = {{(DATA_W-SHORT_W){immVal[SHORT_W-1]}}, immVal[SHORT_W-1:0]};
  assign immLong  = {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal};
  assign addendB  = immSel ? (immWide ? immLong : immShort) : srcVal;

  assign activeMask = laneMask[strobe.widthIdx];
  assign opA        = dstVal  & activeMask;
  assign opB        = addendB & activeMask;
  assign carryIn    = strobe.addCarryIn & flagsIn[FL_CARRY];
  assign sumFull    = {1'b0, opA} + {1'b0, opB} + SUM_W'(carryIn);
  assign sumMasked  = sumFull[DATA_W-1:0] & activeMask;

  for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_lane
    localparam int LANE = SHORT_W << gi;
    if (LANE >= DATA_W) begin : g_full
      assign laneMask[gi] = '1;
    end else begin : g_part
      assign laneMask[gi] = {{(DATA_W-LANE){1'b0}}, {LANE{1'b1}}};
    end
    assign carryAt[gi] = sumFull[LANE];
    assign signA[gi]   = opA[LANE-1];
    assign signB[gi]   = opB[LANE-1];
    assign signR[gi]   = sumFull[LANE-1];
  end

  always_comb begin
    freshFlags           = '0;
    freshFlags[FL_CARRY] = carryAt[strobe.widthIdx];
    freshFlags[FL_PAR]   = ~^sumMasked[SHORT_W-1:0];
    freshFlags[FL_AUX]   = opA[4] ^ opB[4] ^ sumFull[4];
    freshFlags[FL_ZERO]  = (sumMasked == '0);
    freshFlags[FL_SIGN]  = signR[strobe.widthIdx];
    freshFlags[FL_OVF]   = (signA[strobe.widthIdx] == signB[strobe.widthIdx]) &&
                           (signR[strobe.widthIdx] != signA[strobe.widthIdx]);

    writeMask           = {NUM_FLAGS{strobe.writeOthers}};
    writeMask[FL_CARRY] = strobe.writeCarry;

    mergedFlags = (freshFlags & writeMask) | (flagsIn & ~writeMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      resultOut <= '0;
      flagsOut  <= '0;
      flagWe    <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        resultOut <= strobe.accept ? sumMasked : '0;
        flagsOut  <= mergedFlags;
        flagWe    <= writeMask;
      end else begin
        flagWe <= '0;
      end
    end
  end

endmodule

// File: rtl/carry_chain_adder.sv
module carry_chain_adder
  import cca_pkg::*;
#(
  parameter int DATA_W    = cca_pkg::DATA_W,
  parameter int IMM_W     = cca_pkg::IMM_W,
  parameter int NUM_FLAGS = cca_pkg::NUM_FLAGS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           opSel,
  input  logic [1:0]           widthSel,
  input  logic [DATA_W-1:0]    dstVal,
  input  logic [DATA_W-1:0]    srcVal,
  input  logic                 immSel,
  input  logic                 immWide,
  input  logic [IMM_W-1:0]     immVal,
  input  logic [NUM_FLAGS-1:0] flagsIn,
  output logic                 outValid,
  output logic [DATA_W-1:0]    resultOut,
  output logic [NUM_FLAGS-1:0] flagsOut,
  output logic [NUM_FLAGS-1:0] flagWe
);

  ctrlStrobe_t strobe;

  cca_ctrl u_ctrl (
    .opSel    (opSel),
    .widthSel (widthSel),
    .strobe   (strobe)
  );

  cca_datapath #(
    .DATA_W    (DATA_W),
    .IMM_W     (IMM_W),
    .NUM_FLAGS (NUM_FLAGS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .strobe    (strobe),
    .dstVal    (dstVal),
    .srcVal    (srcVal),
    .immSel    (immSel),
    .immWide   (immWide),
    .immVal    (immVal),
    .flagsIn   (flagsIn),
    .outValid  (outValid),
    .resultOut (resultOut),
    .flagsOut  (flagsOut),
    .flagWe    (flagWe)
  );

endmodule

// File: rtl/cca_checker.sv
module cca_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [1:0]  opSel,
  input logic [1:0]  widthSel,
  input logic [5:0]  flagsIn,
  input logic        outValid,
  input logic [63:0] resultOut,
  input logic [5:0]  flagsOut,
  input logic [5:0]  flagWe
);

  function automatic logic [63:0] maskOf(input logic [1:0] w);
    case (w)
      2'd0:    maskOf = 64'h0000_0000_0000_00FF;
      2'd1:    maskOf = 64'h0000_0000_0000_FFFF;
      2'd2:    maskOf = 64'h0000_0000_FFFF_FFFF;
      default: maskOf = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic topOf(input logic [63:0] v, input logic [1:0] w);
    case (w)
      2'd0:    topOf = v[7];
      2'd1:    topOf = v[15];
      2'd2:    topOf = v[31];
      default: topOf = v[63];
    endcase
  endfunction

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((resultOut & ~maskOf($past(widthSel))) == 64'd0)); // R11

  AST_CHAIN_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 2'd2) |->
      (flagWe[5:1] == 5'd0 && flagsOut[5:1] == $past(flagsIn[5:1]))); // R7

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(opSel) == 2'd3 || ($past(opSel) == 2'd2 && $past(widthSel) < 2'd2))) |->
      (flagWe == 6'd0 && resultOut == 64'd0 && flagsOut == $past(flagsIn))); // R8

  AST_SIGN_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagWe[4]) |-> (flagsOut[4] == topOf(resultOut, $past(widthSel)))); // R5

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagWe[3]) |-> (flagsOut[3] == (resultOut == 64'd0))); // R5

  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagWe[1]) |-> (flagsOut[1] == ~^resultOut[7:0])); // R6

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (flagWe == 6'd0)); // R12

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R12

endmodule

bind carry_chain_adder cca_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .widthSel  (widthSel),
  .flagsIn   (flagsIn),
  .outValid  (outValid),
  .resultOut (resultOut),
  .flagsOut  (flagsOut),
  .flagWe    (flagWe)
);

// File: tb/sim_carry_chain_adder.sv
`timescale 1ns/1ps
module sim_carry_chain_adder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [1:0]  widthSel = 2'd0;
  logic [63:0] dstVal = 64'd0;
  logic [63:0] srcVal = 64'd0;
  logic        immSel = 1'b0;
  logic        immWide = 1'b0;
  logic [31:0] immVal = 32'd0;
  logic [5:0]  flagsIn = 6'd0;
  logic        outValid;
  logic [63:0] resultOut;
  logic [5:0]  flagsOut;
  logic [5:0]  flagWe;

  always #4 clk = ~clk;

  carry_chain_adder u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .widthSel(widthSel),
    .dstVal(dstVal), .srcVal(srcVal), .immSel(immSel), .immWide(immWide),
    .immVal(immVal), .flagsIn(flagsIn), .outValid(outValid), .resultOut(resultOut),
    .flagsOut(flagsOut), .flagWe(flagWe)
  );

  typedef struct {
    logic [63:0] res;
    logic [5:0]  fl;
    logic [5:0]  we;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // reference model built from the requirement text
  task automatic drive(input string tag, input logic [1:0] op, input logic [1:0] ws,
                       input logic [63:0] dst, input logic [63:0] src,
                       input logic iS, input logic iW, input logic [31:0] imm,
                       input logic [5:0] fin);
    expItem_t e;
    int w;
    logic [63:0] mask, bsrc, a, b, r;
    logic [64:0] full;
    logic cin, legal, cf, of, af, pf, zf, sf;
    logic [5:0] nf;
    w     = 8 << ws;
    mask  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    bsrc  = iS ? (iW ? {{32{imm[31]}}, imm} : {{56{imm[7]}}, imm[7:0]}) : src;
    a     = dst & mask;
    b     = bsrc & mask;
    legal = (op != 2'd3) && !(op == 2'd2 && ws < 2'd2);
    cin   = (op != 2'd0) ? fin[0] : 1'b0;
    full  = {1'b0, a} + {1'b0, b} + {64'd0, cin};
    r     = full[63:0] & mask;
    cf    = full[w];
    sf    = r[w-1];
    of    = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
    af    = ((a & 64'hF) + (b & 64'hF) + {63'd0, cin}) > 64'd15;
    pf    = ($countones(r[7:0]) % 2) == 0;
    zf    = (r == 64'd0);
    nf    = {of, sf, zf, af, pf, cf};
    if (!legal) begin
      e.res = 64'd0; e.we = 6'd0; e.fl = fin;
    end else begin
      e.res = r;
      e.we  = (op == 2'd2) ? 6'b000001 : 6'b111111;
      e.fl  = (nf & e.we) | (fin & ~e.we);
    end
    e.tag = tag;
    @(negedge clk);
    inValid = 1'b1; opSel = op; widthSel = ws; dstVal = dst; srcVal = src;
    immSel = iS; immWide = iW; immVal = imm; flagsIn = fin;
    scoreQ.push_back(e);
  endtask

  // monitor: outputs settle after the posedge, sampled on the negedge
  always @(negedge clk) begin
    if (rstN && outValid) begin
      expItem_t e;
      checks++;
      if (scoreQ.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected outValid: actual res=%h expected none", resultOut);
      end else begin
        e = scoreQ.pop_front();
        if (resultOut !== e.res || flagsOut !== e.fl || flagWe !== e.we) begin
          failures++;
          $display("FAIL %s: actual res=%h fl=%b we=%b expected res=%h fl=%b we=%b",
                   e.tag, resultOut, flagsOut, flagWe, e.res, e.fl, e.we);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || flagWe !== 6'd0 || resultOut !== 64'd0) begin
      failures++;
      $display("FAIL R12 reset: actual v=%b we=%b res=%h expected 0 0 0", outValid, flagWe, resultOut);
    end
    rstN = 1'b1;

    drive("R1 plain add ignores carry-in", 2'd0, 2'd0, 64'h12, 64'h34, 1'b0, 1'b0, 32'd0, 6'b000001);
    drive("R2 add with carry", 2'd1, 2'd1, 64'h00FF, 64'h0001, 1'b0, 1'b0, 32'd0, 6'b000001);
    drive("R3 carry out at 32 bits", 2'd0, 2'd2, 64'hFFFF_FFFF, 64'h1, 1'b0, 1'b0, 32'd0, 6'd0);
    drive("R4 signed overflow 8 bit", 2'd0, 2'd0, 64'h7F, 64'h01, 1'b0, 1'b0, 32'd0, 6'd0);
    drive("R4 carry overflow and zero together", 2'd0, 2'd0, 64'h80, 64'h80, 1'b0, 1'b0, 32'd0, 6'd0);
    drive("R5 sign at 64 bits", 2'd0, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h2, 1'b0, 1'b0, 32'd0, 6'd0);
    drive("R6 aux carry and parity", 2'd1, 2'd1, 64'h0F, 64'h00, 1'b0, 1'b0, 32'd0, 6'b000001);
    drive("R7 chain 32 keeps flags", 2'd2, 2'd2, 64'hFFFF_FFFF, 64'h0, 1'b0, 1'b0, 32'd0, 6'b111111);
    drive("R7 chain 64 carry ripple", 2'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0, 32'd0, 6'b010101);
    drive("R7 chain 64 no carry-in", 2'd2, 2'd3, 64'h5, 64'h6, 1'b0, 1'b0, 32'd0, 6'b101010);
    drive("R8 chain at 8 bits rejected", 2'd2, 2'd0, 64'h3, 64'h4, 1'b0, 1'b0, 32'd0, 6'b101101);
    drive("R8 chain at 16 bits rejected", 2'd2, 2'd1, 64'h3, 64'h4, 1'b0, 1'b0, 32'd0, 6'b010010);
    drive("R8 reserved opcode rejected", 2'd3, 2'd3, 64'h3, 64'h4, 1'b0, 1'b0, 32'd0, 6'b110011);
    drive("R9 imm8 sign-extended to 16", 2'd0, 2'd1, 64'h5, 64'h0, 1'b1, 1'b0, 32'h0000_00FF, 6'd0);
    drive("R9 imm8 positive at 64", 2'd1, 2'd3, 64'h100, 64'hDEAD, 1'b1, 1'b0, 32'h1234_5670, 6'b000001);
    drive("R10 imm32 sign-extended to 64", 2'd0, 2'd3, 64'h1_0000_0000, 64'h0, 1'b1, 1'b1, 32'h8000_0000, 6'd0);
    drive("R11 upper bits cleared", 2'd0, 2'd0, 64'hABCD_EF01_2345_6701, 64'hFFFF_FFFF_FFFF_FF02, 1'b0, 1'b0, 32'd0, 6'd0);
    for (int k = 0; k < 60; k++) begin
      drive("R3 random operands", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), $urandom, 6'($urandom_range(0, 63)));
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || flagWe !== 6'd0 || scoreQ.size() != 0) begin
      failures++;
      $display("FAIL R12 idle: actual v=%b we=%b pending=%0d expected 0 0 0",
               outValid, flagWe, scoreQ.size());
    end
    report();
  end

endmodule